// File: doc/BRIEF.md
# Decibel-Stepped Signed Sample Attenuator

This block scales a stream of 24-bit two's-complement audio samples by a gain chosen in whole-decibel steps. The range runs from no attenuation down to 30 dB below full scale. It sits between a sample source and an output stage. Each sample arrives with a valid strobe and a 5-bit step index. The index is captured together with that sample, and the scaled sample appears one clock later with its own valid strobe.

The gain for step N is 10^(-N/20). It is stored as an unsigned Q0.24 coefficient, computed at elaboration time and truncated. The sample is sign-extended and multiplied by the zero-extended coefficient, and bits [47:24] of the 48-bit product form the result. This truncates toward negative infinity. Step 0 would need the coefficient 2^24, which does not fit in 24 bits, so a bypass path passes the sample through unchanged.

Top module: `atten_db_step`

## Requirements
- R1: While reset (`rst_n` low) is applied, `out_vld` is 0 and `out_smp` is 0.
- R2: `out_vld` is high in the cycle after a clock edge with `in_vld` high, and low in the cycle after a clock edge with `in_vld` low.
- R3: With `in_idx` equal to 0, the registered output equals the input sample bit for bit.
- R4: With `in_idx` N from 1 to 30, the output equals floor(s * C / 2^24). Here s is the signed sample and C = floor(10^(-N/20) * 2^24). For a non-negative sample the output never exceeds the input.
- R5: Any `in_idx` value from 31 to 31 (all index codes above 30) gives the same result as index 30.
- R6: Scaling is signed. A negative sample gives a negative output, a non-negative sample gives a non-negative output, and a zero sample gives zero.
- R7: A clock edge with `in_vld` low leaves `out_smp` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input sample strobe |
| in_smp | input | 24 | Two's-complement input sample |
| in_idx | input | 5 | Attenuation step in dB (0 to 30; larger values saturate) |
| out_vld | output | 1 | Output sample strobe, one cycle after `in_vld` |
| out_smp | output | 24 | Scaled two's-complement sample |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing;
- exact pass-through at step 0;
- sign preservation and zero preservation;
- the bound that a non-negative sample never grows;
- that the output holds while no sample is valid;
- that the clipped step never exceeds 30.

Only the bench's scenarios can confirm the exact coefficient values and the floor rounding of negative products. The bench drives full-scale positive, full-scale negative, zero, small negative and random samples at every index code. It compares each result with a gain computed from an exponential of its own.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int DATA_W   = 24;
  localparam int COEF_W   = 24;
  localparam int IDX_W    = 5;
  localparam int MAX_STEP = 30;

  // Unsigned Q0.COEF_W gain for a step of n dB below unity, truncated.
  function automatic logic [COEF_W-1:0] db_coef(input int n);
    real lin;
    lin = 10.0 ** (-(real'(n)) / 20.0);
    return COEF_W'($rtoi(lin * (2.0 ** COEF_W)));
  endfunction

  // Signed sample times unsigned coefficient; keep the upper half.
  function automatic logic signed [DATA_W-1:0] apply_gain(
      input logic signed [DATA_W-1:0] smp,
      input logic [COEF_W-1:0]        coef);
    logic signed [DATA_W+COEF_W:0] prod;
    prod = smp * $signed({1'b0, coef});
    return prod[DATA_W+COEF_W-1:COEF_W];
  endfunction
endpackage

// File: rtl/atten_coef_rom.sv
module atten_coef_rom
  import atten_pkg::*;
#(
  parameter int CW   = COEF_W,
  parameter int IW   = IDX_W,
  parameter int MAXS = MAX_STEP
) (
  input  logic [IW-1:0] idx,
  output logic [IW-1:0] step,
  output logic [CW-1:0] coef
);
  localparam int TBL_N = MAXS + 1;

  logic [CW-1:0] tbl [TBL_N];

  for (genvar gi = 0; gi < TBL_N; gi++) begin : g_tbl
    assign tbl[gi] = CW'(db_coef(gi));
  end

  assign step = (idx > IW'(MAXS)) ? IW'(MAXS) : idx;
  assign coef = tbl[step];
endmodule

// File: rtl/atten_scale.sv
module atten_scale
  import atten_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = COEF_W
) (
  input  logic signed [DW-1:0] smp,
  input  logic        [CW-1:0] coef,
  output logic signed [DW-1:0] scaled
);
  logic signed [DW+CW:0] prod;

  assign prod   = smp * $signed({1'b0, coef});
  assign scaled = prod[DW+CW-1:CW];
endmodule

// File: rtl/atten_db_step.sv
module atten_db_step
  import atten_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int CW   = COEF_W,
  parameter int IW   = IDX_W,
  parameter int MAXS = MAX_STEP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_smp,
  input  logic        [IW-1:0] in_idx,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_smp
);
  logic [IW-1:0]        step_w;
  logic [CW-1:0]        coef_w;
  logic signed [DW-1:0] scaled_w;
  logic                 bypass_w;
  logic signed [DW-1:0] next_smp;

  atten_coef_rom #(.CW(CW), .IW(IW), .MAXS(MAXS)) u_rom (
    .idx  (in_idx),
    .step (step_w),
    .coef (coef_w)
  );

  atten_scale #(.DW(DW), .CW(CW)) u_mul (
    .smp    (in_smp),
    .coef   (coef_w),
    .scaled (scaled_w)
  );

  assign bypass_w = (in_idx == '0);
  assign next_smp = bypass_w ? in_smp : scaled_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_smp <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_smp <= next_smp;
    end
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  // R2
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  // R3
  bypass_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_idx == '0) |=> out_smp == $past(in_smp));
  // R4
  no_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_idx != '0 && !in_smp[DW-1]) |=> out_smp <= $past(in_smp));
  // R5
  step_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> step_w <= IW'(MAXS));
  // R6
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_smp[DW-1] == $past(in_smp[DW-1]));
  // R6
  zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_smp == '0) |=> out_smp == '0);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_smp));
endmodule

// File: tb/sim_atten_db_step.sv
module sim_atten_db_step;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_vld = 1'b0;
  logic signed [23:0] in_smp = '0;
  logic        [4:0]  in_idx = '0;
  logic               out_vld;
  logic signed [23:0] out_smp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  atten_db_step u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_smp  (in_smp),
    .in_idx  (in_idx),
    .out_vld (out_vld),
    .out_smp (out_smp)
  );

  function automatic int ref_out(int s, int idx);
    int n;
    real g;
    longint c, p;
    if (idx == 0) return s;
    n = (idx > 30) ? 30 : idx;
    g = $exp(-real'(n) * $ln(10.0) / 20.0);
    c = longint'($floor(g * 16777216.0));
    p = longint'(s) * c;
    return int'(p >>> 24);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(int s, int idx);
    @(negedge clk);
    in_vld = 1'b1;
    in_smp = s[23:0];
    in_idx = idx[4:0];
    @(posedge clk);
    #1;
    check("R2 valid", int'(out_vld), 1);
    check(idx == 0 ? "R3 bypass" : (idx > 30 ? "R5 saturate" : "R4 scale"),
          int'(out_smp), ref_out(s, idx));
    if (s < 0) check("R6 sign", int'(out_smp < 0), 1);
    if (s == 0) check("R6 zero", int'(out_smp), 0);
  endtask

  initial begin
    int corner [5];
    corner[0] = 8388607; corner[1] = -8388608; corner[2] = 0;
    corner[3] = -1;      corner[4] = -5;
    void'($urandom(32'd29));
    repeat (3) @(posedge clk);
    #1;
    // R1
    check("R1 reset vld", int'(out_vld), 0);
    check("R1 reset smp", int'(out_smp), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++)
      for (int k = 0; k < 5; k++) push(corner[k], i);
    // R4 directed: -6 dB step roughly halves full scale
    push(8388607, 6);
    check("R4 half", int'(out_smp > 4194303 && out_smp < 4230000), 1);
    for (int j = 0; j < 400; j++) begin
      logic [31:0] r;
      r = $urandom;
      push(int'($signed(r[23:0])), int'($urandom_range(31, 0)));
    end
    // R7: idle cycle with new data must not change output
    push(1234567, 3);
    begin
      int held;
      held = int'(out_smp);
      @(negedge clk);
      in_vld = 1'b0;
      in_smp = 24'sd777;
      in_idx = 5'd0;
      @(posedge clk);
      #1;
      check("R7 hold", int'(out_smp), held);
      check("R2 drop", int'(out_vld), 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule